// File: doc/BRIEF.md
# Display Line Timing Sequencer

This block produces the horizontal timing of a raster display, one line at a time. It reads a single packed 32-bit timing word that holds three porch and pulse lengths and a coarse line length. From that word it steps through a fixed four-phase cycle on every enabled pixel-clock tick: a line-sync pulse, the back porch, the active pixels, and the front porch. After the front porch it returns to the sync phase.

Four outputs drive the rest of the display pipeline. A line-sync strobe serves either as a passive-panel line clock or as an active-panel horizontal sync. A data-enable marks the active pixels, and a pixel index counts through them. A one-cycle line request tells an upstream fetch engine to begin loading pixel data for the line that is starting. Writes to the timing word go into a holding register. The sequencer copies that register into its working copy only when a new line enters the sync phase, so every line runs on a single consistent set of settings.

Top module: `lcd_line_timer`

## Requirements
- R1: While `rst` is high, and after it is released, `line_sync`, `data_en`, `pix_idx`, `line_req` and `cfg_rdata` are all zero.
- R2: A write stores `cfg_wdata` into the timing word. `cfg_rdata` returns bits 31:2 as written and returns zero in bits 1:0, whatever was written to those two bits.
- R3: The timing word holds the back-porch length minus one in bits 31:24, the front-porch length minus one in bits 23:16, the sync length minus one in bits 15:8, and the line-length code L in bits 7:2. Once running, each line spends (sync+1) ticks with `line_sync` high, then (back+1) ticks, then 16×(L+1) active ticks, then (front+1) ticks, and then starts over.
- R4: `data_en` is high only during the active ticks. `pix_idx` runs 0, 1, 2, … through the active window and reads 0 at every other time.
- R5: `line_req` is high for exactly one clock cycle as each line enters its sync phase, and also in the first cycle after `enable` goes high.
- R6: When `passive_mode` is 1, a sync or back-porch field below 1 is used as 1, which gives a minimum of 2 ticks. When `passive_mode` is 0, no limit is applied. The front porch is never limited.
- R7: A write made partway through a line does not change that line. The new value takes effect from the next sync phase.
- R8: While `enable` is low, all four timing outputs are low. After `enable` rises, the sequence restarts at the first sync tick.
- R9: A clock cycle with `pix_en` low leaves the phase, the pixel index and every timing output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the sequencer. When low, the sequencer is held at the start of sync |
| passive_mode | input | 1 | 1 selects the passive panel, which applies the minimum length of 2 |
| pix_en | input | 1 | Pixel-clock enable, one tick per high cycle |
| cfg_we | input | 1 | Write strobe for the timing word |
| cfg_wdata | input | 32 | Timing word write data |
| cfg_rdata | output | 32 | Timing word read-back, with bits 1:0 always zero |
| line_sync | output | 1 | Line clock or horizontal sync, active high |
| data_en | output | 1 | High during the active pixels |
| pix_idx | output | 10 | Index of the active pixel, 0 outside the active window |
| line_req | output | 1 | One-cycle fetch request at each line start |

## Verification
The bench builds the block with its default parameters: 8-bit porch fields, a 6-bit line code in units of 16, and a passive-mode minimum of 2. With these values both extremes of the fields can be reached in a short run. All-zero fields exercise the one-tick porches and the clamp. All-ones fields give a 256-tick porch and a 1024-pixel line, which reaches the top value of the 10-bit index. Most random configurations keep the lines short, so that many line wraps, shadow reloads, enable restarts and stalled pixel ticks fit in the run.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } lcdt_phase_e;

  function automatic int unsigned lcdt_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcdt_cfg_reg.sv
module lcdt_cfg_reg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (we) begin
      word_q <= {wdata[WORD_W-1:2], 2'b00};
    end
  end

  assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> (word_q[WORD_W-1:2] == $past(wdata[WORD_W-1:2])) && (word_q[1:0] == 2'b00));

endmodule

// File: rtl/lcdt_shadow.sv
module lcdt_shadow #(
  parameter int FLD_W       = 8,
  parameter int LEN_W       = 6,
  parameter int UNIT_LG2    = 4,
  parameter int MIN_PASSIVE = 2,
  parameter int CNT_W       = 10,
  localparam int IN_W       = 3*FLD_W + LEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             passive,
  input  logic [IN_W-1:0]  word_hi,
  output logic [CNT_W-1:0] sync_last,
  output logic [CNT_W-1:0] back_last,
  output logic [CNT_W-1:0] front_last,
  output logic [CNT_W-1:0] act_last
);

  localparam logic [FLD_W-1:0] MIN_F  = FLD_W'(MIN_PASSIVE - 1);
  localparam logic [CNT_W-1:0] MIN_CW = CNT_W'(MIN_PASSIVE - 1);

  // slot 0 = sync, slot 1 = front porch, slot 2 = back porch
  for (genvar g = 0; g < 3; g++) begin : g_fld
    localparam bit CLAMP = (g != 1);
    logic [FLD_W-1:0] fld;
    logic [FLD_W-1:0] fld_c;
    logic [CNT_W-1:0] last_q;

    assign fld = word_hi[LEN_W + g*FLD_W +: FLD_W];

    always_comb begin
      fld_c = fld;
      if (CLAMP && passive && (fld < MIN_F)) fld_c = MIN_F;
    end

    always_ff @(posedge clk) begin
      if (rst)       last_q <= '0;
      else if (load) last_q <= CNT_W'(fld_c);
    end
  end

  logic [LEN_W-1:0] ppl_q;
  always_ff @(posedge clk) begin
    if (rst)       ppl_q <= '0;
    else if (load) ppl_q <= word_hi[LEN_W-1:0];
  end

  assign sync_last  = g_fld[0].last_q;
  assign front_last = g_fld[1].last_q;
  assign back_last  = g_fld[2].last_q;
  assign act_last   = CNT_W'({ppl_q, {UNIT_LG2{1'b1}}});

  assert_clamp_R6: assert property (@(posedge clk) disable iff (rst)
    (load && passive) |=> (sync_last >= MIN_CW) && (back_last >= MIN_CW));

  assert_noclamp_R6: assert property (@(posedge clk) disable iff (rst)
    (load && !passive) |=> (sync_last == CNT_W'($past(word_hi[LEN_W +: FLD_W]))));

endmodule

// File: rtl/lcdt_seq.sv
module lcdt_seq
  import lcdt_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             pix_en,
  input  logic [CNT_W-1:0] sync_last,
  input  logic [CNT_W-1:0] back_last,
  input  logic [CNT_W-1:0] act_last,
  input  logic [CNT_W-1:0] front_last,
  output logic             shadow_load,
  output logic             line_sync,
  output logic             data_en,
  output logic [IDX_W-1:0] pix_idx,
  output logic             line_req
);

  lcdt_phase_e      phase_q, phase_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, cur_last;
  logic             run_q, tick, at_end, wrap;

  assign tick = enable && run_q && pix_en;

  always_comb begin
    case (phase_q)
      PH_SYNC: cur_last = sync_last;
      PH_BACK: cur_last = back_last;
      PH_ACT:  cur_last = act_last;
      default: cur_last = front_last;
    endcase
  end

  assign at_end = (cnt_q == cur_last);
  assign wrap   = tick && at_end && (phase_q == PH_FRONT);
  assign shadow_load = !enable || wrap;

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    if (!enable) begin
      phase_n = PH_SYNC;
      cnt_n   = '0;
    end else if (tick) begin
      if (at_end) begin
        cnt_n = '0;
        case (phase_q)
          PH_SYNC: phase_n = PH_BACK;
          PH_BACK: phase_n = PH_ACT;
          PH_ACT:  phase_n = PH_FRONT;
          default: phase_n = PH_SYNC;
        endcase
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_SYNC;
      cnt_q     <= '0;
      run_q     <= 1'b0;
      line_sync <= 1'b0;
      data_en   <= 1'b0;
      pix_idx   <= '0;
      line_req  <= 1'b0;
    end else begin
      phase_q   <= phase_n;
      cnt_q     <= cnt_n;
      run_q     <= enable;
      line_sync <= enable && (phase_n == PH_SYNC);
      data_en   <= enable && (phase_n == PH_ACT);
      pix_idx   <= (enable && (phase_n == PH_ACT)) ? cnt_n[IDX_W-1:0] : '0;
      line_req  <= enable && (!run_q || wrap);
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (enable && run_q && !pix_en) |=> $stable(phase_q) && $stable(cnt_q) &&
      $stable(line_sync) && $stable(data_en) && $stable(pix_idx));

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !line_sync && !data_en && !line_req && (pix_idx == '0));

  assert_req_single_R5: assert property (@(posedge clk) disable iff (rst)
    line_req |=> !line_req);

  assert_idx_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && (phase_q == PH_ACT) && !at_end) |=> (pix_idx == $past(pix_idx) + 1'b1) && data_en);

endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
  import lcdt_pkg::*;
#(
  parameter int FLD_W       = 8,
  parameter int LEN_W       = 6,
  parameter int UNIT_LG2    = 4,
  parameter int MIN_PASSIVE = 2,
  localparam int WORD_W     = 3*FLD_W + LEN_W + 2,
  localparam int IDX_W      = LEN_W + UNIT_LG2,
  localparam int CNT_W      = lcdt_max(IDX_W, FLD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              passive_mode,
  input  logic              pix_en,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  output logic              line_sync,
  output logic              data_en,
  output logic [IDX_W-1:0]  pix_idx,
  output logic              line_req
);

  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  sync_last, back_last, front_last, act_last;
  logic              shadow_load;

  lcdt_cfg_reg #(.WORD_W(WORD_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .word_q (word_q)
  );

  assign cfg_rdata = word_q;

  lcdt_shadow #(
    .FLD_W       (FLD_W),
    .LEN_W       (LEN_W),
    .UNIT_LG2    (UNIT_LG2),
    .MIN_PASSIVE (MIN_PASSIVE),
    .CNT_W       (CNT_W)
  ) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .load       (shadow_load),
    .passive    (passive_mode),
    .word_hi    (word_q[WORD_W-1:2]),
    .sync_last  (sync_last),
    .back_last  (back_last),
    .front_last (front_last),
    .act_last   (act_last)
  );

  lcdt_seq #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .pix_en      (pix_en),
    .sync_last   (sync_last),
    .back_last   (back_last),
    .act_last    (act_last),
    .front_last  (front_last),
    .shadow_load (shadow_load),
    .line_sync   (line_sync),
    .data_en     (data_en),
    .pix_idx     (pix_idx),
    .line_req    (line_req)
  );

endmodule

// File: tb/lcd_line_timer_bench.sv
module lcd_line_timer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        passive_mode = 1'b0;
  logic        pix_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        line_sync, data_en, line_req;
  logic [9:0]  pix_idx;

  always #2 clk = ~clk;

  lcd_line_timer u_lcd_line_timer (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .passive_mode (passive_mode),
    .pix_en       (pix_en),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .line_sync    (line_sync),
    .data_en      (data_en),
    .pix_idx      (pix_idx),
    .line_req     (line_req)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string scen  = "R1";
  bit    done  = 1'b0;

  // reference model of the requirements
  logic [31:0] m_reg;
  bit          m_run, m_req;
  int          m_ph, m_cnt;
  int          m_len [4];

  function automatic int porch_len(input logic [7:0] f, input bit clampable, input bit pas);
    int n = int'(f) + 1;
    if (clampable && pas && n < 2) n = 2;
    return n;
  endfunction

  function automatic logic [31:0] mk(input int bp, input int fp, input int sw, input int ppl, input int rsv);
    return {8'(bp), 8'(fp), 8'(sw), 6'(ppl), 2'(rsv)};
  endfunction

  task automatic model_load(input logic [31:0] w, input bit pas);
    m_len[0] = porch_len(w[15:8], 1'b1, pas);
    m_len[1] = porch_len(w[31:24], 1'b1, pas);
    m_len[2] = 16 * (int'(w[7:2]) + 1);
    m_len[3] = porch_len(w[23:16], 1'b0, pas);
  endtask

  always @(posedge clk) begin
    logic [31:0] old;
    if (rst) begin
      m_reg = '0; m_run = 0; m_req = 0; m_ph = 0; m_cnt = 0;
      m_len[0] = 1; m_len[1] = 1; m_len[2] = 16; m_len[3] = 1;
    end else begin
      old = m_reg;
      if (cfg_we) m_reg = cfg_wdata & 32'hFFFF_FFFC;
      if (!enable) begin
        m_run = 0; m_req = 0; m_ph = 0; m_cnt = 0;
        model_load(old, passive_mode);
      end else if (!m_run) begin
        m_run = 1; m_req = 1;
      end else if (pix_en) begin
        m_req = 0;
        if (m_cnt == m_len[m_ph] - 1) begin
          m_cnt = 0;
          if (m_ph == 3) begin
            m_ph = 0; m_req = 1;
            model_load(old, passive_mode);
          end else m_ph = m_ph + 1;
        end else m_cnt = m_cnt + 1;
      end else m_req = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (scenario %s) %s: actual=%0d expected=%0d", req, scen, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit e_de;
    e_de = m_run && (m_ph == 2);
    chk("R3", "line_sync", int'(line_sync), int'(m_run && (m_ph == 0)));
    chk("R4", "data_en",   int'(data_en),   int'(e_de));
    chk("R4", "pix_idx",   int'(pix_idx),   e_de ? m_cnt : 0);
    chk("R5", "line_req",  int'(line_req),  int'(m_req && m_run));
    chk("R2", "cfg_rdata", int'(cfg_rdata), int'(m_reg));
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
      cfg_we = 1'b0;
    end
  endtask

  task automatic wr(input logic [31:0] w);
    cfg_we = 1'b1;
    cfg_wdata = w;
    cyc(1);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd2718));
    // R1: reset state
    scen = "R1";
    cyc(3);
    rst = 1'b0;
    cyc(2);

    // R3 / R2: basic active-mode lines, reserved bits written as ones
    scen = "R3";
    wr(mk(3, 1, 2, 0, 3));
    cyc(2);
    enable = 1'b1; pix_en = 1'b1;
    cyc(90);

    // R6: zero fields, passive clamps, active does not
    scen = "R6";
    enable = 1'b0;
    wr(mk(0, 0, 0, 0, 0));
    passive_mode = 1'b1;
    cyc(2);
    enable = 1'b1;
    cyc(70);
    enable = 1'b0; passive_mode = 1'b0;
    cyc(2);
    enable = 1'b1;
    cyc(70);

    // R9: stalled pixel ticks
    scen = "R9";
    wr(mk(2, 4, 1, 1, 0));
    for (int i = 0; i < 200; i++) begin
      pix_en = ($urandom % 2) != 0;
      cyc(1);
    end
    pix_en = 1'b1;

    // R7: writes at arbitrary points within a line
    scen = "R7";
    for (int i = 0; i < 8; i++) begin
      cyc(5 + $urandom % 30);
      wr(mk($urandom % 6, $urandom % 6, $urandom % 6, $urandom % 3, $urandom % 4));
    end
    cyc(120);

    // R8: enable dropped mid-line, then restarted
    scen = "R8";
    cyc(13);
    enable = 1'b0;
    cyc(6);
    enable = 1'b1;
    cyc(60);

    // random configurations
    for (int it = 0; it < 30; it++) begin
      scen = ((it % 2) == 0) ? "R4" : "R5";
      if ($urandom % 3 == 0) begin
        enable = 1'b0;
        passive_mode = ($urandom % 2) != 0;
        cyc(1 + $urandom % 3);
        enable = 1'b1;
      end
      wr(mk($urandom % 8, $urandom % 8, $urandom % 8, $urandom % 4, $urandom % 4));
      for (int k = 0; k < 60 + int'($urandom % 120); k++) begin
        pix_en = ($urandom % 4) != 0;
        cyc(1);
      end
    end
    pix_en = 1'b1;

    // R3: widest fields: 256-tick porches and 1024-pixel line
    scen = "R3";
    enable = 1'b0; passive_mode = 1'b0;
    wr(mk(255, 255, 255, 63, 0));
    cyc(2);
    enable = 1'b1;
    cyc(2 * (256 * 3 + 1024) + 20);

    done = 1'b1;
    report();
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (scenario %s): actual=timeout expected=completion", scen);
      report();
    end
  end

endmodule